// File: doc/BRIEF.md
# AXI to TileLink-UL Request/Response Bridge

This block sits behind an AXI subordinate port and turns each single-beat AXI access into one TileLink Uncached Lightweight (TL-UL) channel A message. A write is taken only when its address and its data are offered together, so the two AXI write channels become one Put message. A read becomes a Get. The AXI ID travels as the TL source, and the transfer size field passes through unchanged.

Responses come back on TL-UL channel D. They are steered onto the AXI write-response or read-data channel by their opcode. The D message is consumed only in the cycle in which the AXI side takes the response. The TL error flag becomes the SLVERR response code.

Only one request is in flight at the bridge's edge at a time. While a channel A message waits for the TL side, no new AXI request is accepted. Bursts, atomics and response reordering are not handled.

Top module: `axi_tlul_bridge`

## Requirements
- R1: A write is accepted only when the write-address valid and the write-data valid are both high. The two AXI write readies then rise together in that cycle, and the channel A message is valid from the next clock edge. With only one of the two valids high, neither ready rises and no message appears.
- R2: A write whose strobe sets every byte lane of its transfer window is issued with opcode 0 (PutFullData), carrying address, ID, size, data and strobe unchanged. The window is the 2^size lanes of the size-aligned block that contains the lane given by the low address bits (bits 4:0 for a 256-bit bus).
- R3: A write whose strobe leaves at least one lane of that window clear is issued with opcode 1 (PutPartialData).
- R4: A read is issued with opcode 4 (Get), carrying the read address, ID and size.
- R5: A channel A message stays valid with all fields stable until channel A ready is high at a clock edge. While a message is pending, all AXI request readies stay low.
- R6: A D message with opcode 0 (AccessAck) appears as a write response whose ID is the D source. The response code is 0 (OKAY) when the D error flag is clear and 2 (SLVERR) when it is set.
- R7: A D message with opcode 1 (AccessAckData) appears as a read beat whose ID is the D source and whose data is the D data. The response code is 0 when the error flag is clear and 2 when it is set.
- R8: D ready is high exactly when the AXI response that the D message produced is valid and its AXI ready is high. While that AXI ready is low, D ready stays low and the response is held.
- R9: When a complete write and a read are both offered with nothing pending, the write is taken first. The read is taken once the write's channel A message has left.
- R10: A synchronous active-high reset clears the pending channel A message and holds every valid output and every AXI ready low.
- R11: Size values 0 to 5 (1 to 32 bytes) reach channel A unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| aw_valid | input | 1 | Write address valid |
| aw_ready | output | 1 | Write address ready |
| aw_addr | input | 32 | Write address |
| aw_id | input | 6 | Write ID |
| aw_size | input | 3 | Write size, log2 of bytes |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data ready |
| w_data | input | 256 | Write data |
| w_strb | input | 32 | Write byte strobes |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_id | output | 6 | Write response ID |
| b_resp | output | 2 | Write response code |
| ar_valid | input | 1 | Read address valid |
| ar_ready | output | 1 | Read address ready |
| ar_addr | input | 32 | Read address |
| ar_id | input | 6 | Read ID |
| ar_size | input | 3 | Read size, log2 of bytes |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_id | output | 6 | Read data ID |
| r_data | output | 256 | Read data |
| r_resp | output | 2 | Read response code |
| a_valid | output | 1 | Channel A valid |
| a_ready | input | 1 | Channel A ready |
| a_opcode | output | 3 | Channel A opcode |
| a_address | output | 32 | Channel A address |
| a_source | output | 6 | Channel A source |
| a_size | output | 3 | Channel A size |
| a_data | output | 256 | Channel A data |
| a_mask | output | 32 | Channel A byte mask |
| d_valid | input | 1 | Channel D valid |
| d_ready | output | 1 | Channel D ready |
| d_opcode | input | 3 | Channel D opcode |
| d_source | input | 6 | Channel D source |
| d_data | input | 256 | Channel D data |
| d_error | input | 1 | Channel D error flag |

## Verification
The AXI request readies and every response output follow their inputs combinationally. They are due in the same cycle as the stimulus, so the bench drives at the falling edge and samples one time unit later. A channel A message is due one rising edge after the handshake that accepted it, and its clearing is due one rising edge after channel A ready is seen. The bench samples both at the next falling edge, never at the edge itself. Hold behaviour is checked across two further falling edges while new requests are offered.

// File: rtl/axtl_pkg.sv
package axtl_pkg;
   typedef enum logic [2:0] {
      A_PUT_FULL = 3'd0,
      A_PUT_PART = 3'd1,
      A_GET      = 3'd4
   } a_op_e;

   localparam logic [2:0] D_ACK      = 3'd0;
   localparam logic [2:0] D_ACK_DATA = 3'd1;

   localparam logic [1:0] RESP_OKAY   = 2'b00;
   localparam logic [1:0] RESP_SLVERR = 2'b10;

   localparam int SIZE_W = 3;
endpackage

// File: rtl/axtl_lane_window.sv
// Decides whether a strobe covers every lane of the size-aligned window.
module axtl_lane_window #(
   parameter int STRB_W = 32,
   parameter int OFF_W  = 5
) (
   input  logic [OFF_W-1:0]  off,
   input  logic [2:0]        size,
   input  logic [STRB_W-1:0] strb,
   output logic              full
);
   logic [STRB_W-1:0] in_win;

   for (genvar i = 0; i < STRB_W; i++) begin : g_lane
      localparam logic [OFF_W-1:0] LANE = OFF_W'(i);
      // A lane belongs to the window when it shares the size-aligned block.
      assign in_win[i] = ((LANE >> size) == (off >> size));
   end

   assign full = &(strb | ~in_win);
endmodule

// File: rtl/axtl_req_stage.sv
// Accepts one AXI request at a time and holds it as a channel A message.
module axtl_req_stage
   import axtl_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int ID_W        = 6,
   parameter int DATA_W      = 256,
   parameter bit WRITE_FIRST = 1'b1,
   localparam int STRB_W     = DATA_W / 8,
   localparam int OFF_W      = $clog2(STRB_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [ID_W-1:0]   aw_id,
   input  logic [SIZE_W-1:0] aw_size,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [DATA_W-1:0] w_data,
   input  logic [STRB_W-1:0] w_strb,
   input  logic              ar_valid,
   output logic              ar_ready,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [ID_W-1:0]   ar_id,
   input  logic [SIZE_W-1:0] ar_size,
   output logic              a_valid,
   input  logic              a_ready,
   output logic [2:0]        a_opcode,
   output logic [ADDR_W-1:0] a_address,
   output logic [ID_W-1:0]   a_source,
   output logic [SIZE_W-1:0] a_size,
   output logic [DATA_W-1:0] a_data,
   output logic [STRB_W-1:0] a_mask
);
   logic              busy_q;
   a_op_e             op_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ID_W-1:0]   src_q;
   logic [SIZE_W-1:0] size_q;
   logic [DATA_W-1:0] data_q;
   logic [STRB_W-1:0] mask_q;

   logic idle, wr_offer, rd_offer, take_wr, take_rd, wr_full;

   assign idle     = ~busy_q & ~rst;
   assign wr_offer = aw_valid & w_valid;
   assign rd_offer = ar_valid;

   if (WRITE_FIRST) begin : g_wr_first
      assign take_wr = idle & wr_offer;
      assign take_rd = idle & rd_offer & ~wr_offer;
   end else begin : g_rd_first
      assign take_rd = idle & rd_offer;
      assign take_wr = idle & wr_offer & ~rd_offer;
   end

   axtl_lane_window #(.STRB_W(STRB_W), .OFF_W(OFF_W)) u_win (
      .off  (aw_addr[OFF_W-1:0]),
      .size (aw_size),
      .strb (w_strb),
      .full (wr_full)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         busy_q <= 1'b0;
         op_q   <= A_GET;
         addr_q <= '0;
         src_q  <= '0;
         size_q <= '0;
         data_q <= '0;
         mask_q <= '0;
      end else if (take_wr) begin
         busy_q <= 1'b1;
         op_q   <= wr_full ? A_PUT_FULL : A_PUT_PART;
         addr_q <= aw_addr;
         src_q  <= aw_id;
         size_q <= aw_size;
         data_q <= w_data;
         mask_q <= w_strb;
      end else if (take_rd) begin
         busy_q <= 1'b1;
         op_q   <= A_GET;
         addr_q <= ar_addr;
         src_q  <= ar_id;
         size_q <= ar_size;
         data_q <= '0;
         mask_q <= '1;
      end else if (busy_q && a_ready) begin
         busy_q <= 1'b0;
      end
   end

   assign aw_ready  = take_wr;
   assign w_ready   = take_wr;
   assign ar_ready  = take_rd;
   assign a_valid   = busy_q;
   assign a_opcode  = op_q;
   assign a_address = addr_q;
   assign a_source  = src_q;
   assign a_size    = size_q;
   assign a_data    = data_q;
   assign a_mask    = mask_q;
endmodule

// File: rtl/axtl_resp_map.sv
// Steers channel D responses onto the AXI write-response or read-data channel.
module axtl_resp_map
   import axtl_pkg::*;
#(
   parameter int ID_W   = 6,
   parameter int DATA_W = 256
) (
   input  logic              rst,
   input  logic              d_valid,
   output logic              d_ready,
   input  logic [2:0]        d_opcode,
   input  logic [ID_W-1:0]   d_source,
   input  logic [DATA_W-1:0] d_data,
   input  logic              d_error,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [ID_W-1:0]   b_id,
   output logic [1:0]        b_resp,
   output logic              r_valid,
   input  logic              r_ready,
   output logic [ID_W-1:0]   r_id,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp
);
   logic live, is_ack, is_data;
   logic [1:0] code;

   assign live    = d_valid & ~rst;
   assign is_ack  = live & (d_opcode == D_ACK);
   assign is_data = live & (d_opcode == D_ACK_DATA);
   assign code    = d_error ? RESP_SLVERR : RESP_OKAY;

   assign b_valid = is_ack;
   assign b_id    = d_source;
   assign b_resp  = code;
   assign r_valid = is_data;
   assign r_id    = d_source;
   assign r_data  = d_data;
   assign r_resp  = code;
   assign d_ready = (is_ack & b_ready) | (is_data & r_ready);
endmodule

// File: rtl/axi_tlul_bridge.sv
module axi_tlul_bridge
   import axtl_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int ID_W        = 6,
   parameter int DATA_W      = 256,
   parameter bit WRITE_FIRST = 1'b1,
   localparam int STRB_W     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [ID_W-1:0]   aw_id,
   input  logic [2:0]        aw_size,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [DATA_W-1:0] w_data,
   input  logic [STRB_W-1:0] w_strb,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [ID_W-1:0]   b_id,
   output logic [1:0]        b_resp,
   input  logic              ar_valid,
   output logic              ar_ready,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [ID_W-1:0]   ar_id,
   input  logic [2:0]        ar_size,
   output logic              r_valid,
   input  logic              r_ready,
   output logic [ID_W-1:0]   r_id,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp,
   output logic              a_valid,
   input  logic              a_ready,
   output logic [2:0]        a_opcode,
   output logic [ADDR_W-1:0] a_address,
   output logic [ID_W-1:0]   a_source,
   output logic [2:0]        a_size,
   output logic [DATA_W-1:0] a_data,
   output logic [STRB_W-1:0] a_mask,
   input  logic              d_valid,
   output logic              d_ready,
   input  logic [2:0]        d_opcode,
   input  logic [ID_W-1:0]   d_source,
   input  logic [DATA_W-1:0] d_data,
   input  logic              d_error
);
   if (DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power of two of at least 16");
   end
   if (ADDR_W < $clog2(STRB_W)) begin : g_bad_addr_w
      $error("ADDR_W must cover the byte offset within a bus word");
   end
   if (ID_W < 1) begin : g_bad_id_w
      $error("ID_W must be at least 1");
   end

   axtl_req_stage #(
      .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W), .WRITE_FIRST(WRITE_FIRST)
   ) u_req (
      .clk(clk), .rst(rst),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr),
      .aw_id(aw_id), .aw_size(aw_size),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
      .ar_id(ar_id), .ar_size(ar_size),
      .a_valid(a_valid), .a_ready(a_ready), .a_opcode(a_opcode),
      .a_address(a_address), .a_source(a_source), .a_size(a_size),
      .a_data(a_data), .a_mask(a_mask)
   );

   axtl_resp_map #(.ID_W(ID_W), .DATA_W(DATA_W)) u_resp (
      .rst(rst),
      .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode),
      .d_source(d_source), .d_data(d_data), .d_error(d_error),
      .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id), .b_resp(b_resp),
      .r_valid(r_valid), .r_ready(r_ready), .r_id(r_id), .r_data(r_data),
      .r_resp(r_resp)
   );
endmodule

// File: rtl/axi_tlul_bridge_chk.sv
module axi_tlul_bridge_chk #(
   parameter int ADDR_W = 32,
   parameter int ID_W   = 6,
   parameter int DATA_W = 256,
   localparam int STRB_W = DATA_W / 8
) (
   input logic              clk,
   input logic              rst,
   input logic              aw_valid,
   input logic              aw_ready,
   input logic              w_valid,
   input logic              w_ready,
   input logic              ar_valid,
   input logic              ar_ready,
   input logic              a_valid,
   input logic              a_ready,
   input logic [2:0]        a_opcode,
   input logic [ADDR_W-1:0] a_address,
   input logic [ID_W-1:0]   a_source,
   input logic [2:0]        a_size,
   input logic [DATA_W-1:0] a_data,
   input logic [STRB_W-1:0] a_mask,
   input logic              d_ready,
   input logic              d_error,
   input logic              b_valid,
   input logic              b_ready,
   input logic [1:0]        b_resp,
   input logic              r_valid,
   input logic              r_ready
);
   p_wr_pair_r1: assert property (@(posedge clk) disable iff (rst)
      (aw_ready | w_ready) |-> (aw_ready & w_ready & aw_valid & w_valid));

   p_wr_next_r1: assert property (@(posedge clk) disable iff (rst)
      (aw_valid & aw_ready) |=> a_valid);

   p_get_op_r4: assert property (@(posedge clk) disable iff (rst)
      (ar_valid & ar_ready) |=> (a_valid & (a_opcode == 3'd4)));

   p_hold_r5: assert property (@(posedge clk) disable iff (rst)
      (a_valid & ~a_ready) |=> (a_valid & $stable(a_opcode) & $stable(a_address)
         & $stable(a_source) & $stable(a_size) & $stable(a_data) & $stable(a_mask)));

   p_busy_r5: assert property (@(posedge clk) disable iff (rst)
      a_valid |-> ~(aw_ready | w_ready | ar_ready));

   p_bresp_r6: assert property (@(posedge clk) disable iff (rst)
      b_valid |-> (b_resp == (d_error ? 2'b10 : 2'b00)));

   p_one_resp_r7: assert property (@(posedge clk) disable iff (rst)
      $onehot0({b_valid, r_valid}));

   p_dready_r8: assert property (@(posedge clk) disable iff (rst)
      d_ready |-> ((b_valid & b_ready) | (r_valid & r_ready)));
endmodule

bind axi_tlul_bridge axi_tlul_bridge_chk #(
   .ADDR_W(ADDR_W), .ID_W(ID_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst(rst),
   .aw_valid(aw_valid), .aw_ready(aw_ready), .w_valid(w_valid), .w_ready(w_ready),
   .ar_valid(ar_valid), .ar_ready(ar_ready),
   .a_valid(a_valid), .a_ready(a_ready), .a_opcode(a_opcode),
   .a_address(a_address), .a_source(a_source), .a_size(a_size),
   .a_data(a_data), .a_mask(a_mask),
   .d_ready(d_ready), .d_error(d_error),
   .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
   .r_valid(r_valid), .r_ready(r_ready)
);

// File: tb/tb_axi_tlul_bridge.sv
module tb_axi_tlul_bridge;
   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         aw_valid = 0, aw_ready;
   logic [31:0]  aw_addr = 0;
   logic [5:0]   aw_id = 0;
   logic [2:0]   aw_size = 0;
   logic         w_valid = 0, w_ready;
   logic [255:0] w_data = 0;
   logic [31:0]  w_strb = 0;
   logic         b_valid, b_ready = 0;
   logic [5:0]   b_id;
   logic [1:0]   b_resp;
   logic         ar_valid = 0, ar_ready;
   logic [31:0]  ar_addr = 0;
   logic [5:0]   ar_id = 0;
   logic [2:0]   ar_size = 0;
   logic         r_valid, r_ready = 0;
   logic [5:0]   r_id;
   logic [255:0] r_data;
   logic [1:0]   r_resp;
   logic         a_valid, a_ready = 0;
   logic [2:0]   a_opcode;
   logic [31:0]  a_address;
   logic [5:0]   a_source;
   logic [2:0]   a_size;
   logic [255:0] a_data;
   logic [31:0]  a_mask;
   logic         d_valid = 0, d_ready;
   logic [2:0]   d_opcode = 0;
   logic [5:0]   d_source = 0;
   logic [255:0] d_data = 0;
   logic         d_error = 0;

   int n_chk = 0;
   int n_fail = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   axi_tlul_bridge dut (
      .clk(clk), .rst(rst),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_id(aw_id),
      .aw_size(aw_size), .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
      .w_strb(w_strb), .b_valid(b_valid), .b_ready(b_ready), .b_id(b_id),
      .b_resp(b_resp), .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr),
      .ar_id(ar_id), .ar_size(ar_size), .r_valid(r_valid), .r_ready(r_ready),
      .r_id(r_id), .r_data(r_data), .r_resp(r_resp), .a_valid(a_valid),
      .a_ready(a_ready), .a_opcode(a_opcode), .a_address(a_address),
      .a_source(a_source), .a_size(a_size), .a_data(a_data), .a_mask(a_mask),
      .d_valid(d_valid), .d_ready(d_ready), .d_opcode(d_opcode),
      .d_source(d_source), .d_data(d_data), .d_error(d_error)
   );

   task automatic chk(input bit ok, input string req, input logic [255:0] act,
                      input logic [255:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Releases a pending channel A message and checks that it clears.
   task automatic drain_a(input string req);
      a_ready = 1'b1;
      @(posedge clk); #1;
      a_ready = 1'b0;
      @(negedge clk);
      chk(!a_valid, req, a_valid, 0);
   endtask

   task automatic t_reset_state();
      @(negedge clk);
      aw_valid = 1; w_valid = 1; ar_valid = 1; d_valid = 1; d_opcode = 3'd0;
      #1;
      // R10: in reset nothing is valid and no request is accepted
      chk(!a_valid && !b_valid && !r_valid, "R10 valids in reset",
          {a_valid, b_valid, r_valid}, 0);
      chk(!aw_ready && !w_ready && !ar_ready, "R10 readies in reset",
          {aw_ready, w_ready, ar_ready}, 0);
      aw_valid = 0; w_valid = 0; ar_valid = 0; d_valid = 0;
   endtask

   task automatic t_write(input logic [31:0] addr, input logic [5:0] id,
                          input logic [2:0] size, input logic [255:0] data,
                          input logic [31:0] strb, input logic [2:0] exp_op,
                          input string req);
      @(negedge clk);
      aw_valid = 1; aw_addr = addr; aw_id = id; aw_size = size;
      w_valid = 1; w_data = data; w_strb = strb;
      #1;
      chk(aw_ready && w_ready, "R1 joint write readies", {aw_ready, w_ready}, 2'b11);
      @(posedge clk); #1;
      aw_valid = 0; w_valid = 0;
      @(negedge clk);
      chk(a_valid, "R1 message next cycle", a_valid, 1);
      chk(a_opcode == exp_op, req, a_opcode, exp_op);
      chk(a_address == addr && a_source == id && a_data == data && a_mask == strb,
          "R2 write fields", a_address, addr);
      chk(a_size == size, "R11 size unchanged", a_size, size);
      drain_a("R5 clears after a_ready");
   endtask

   task automatic t_half_write();
      @(negedge clk);
      aw_valid = 1; aw_addr = 32'h40;
      #1;
      chk(!aw_ready && !w_ready, "R1 address alone", {aw_ready, w_ready}, 0);
      @(negedge clk);
      chk(!a_valid, "R1 no message from address alone", a_valid, 0);
      aw_valid = 0; w_valid = 1;
      #1;
      chk(!aw_ready && !w_ready, "R1 data alone", {aw_ready, w_ready}, 0);
      @(negedge clk);
      chk(!a_valid, "R1 no message from data alone", a_valid, 0);
      w_valid = 0;
   endtask

   task automatic t_read(input logic [31:0] addr, input logic [5:0] id,
                         input logic [2:0] size);
      @(negedge clk);
      ar_valid = 1; ar_addr = addr; ar_id = id; ar_size = size;
      #1;
      chk(ar_ready, "R4 read ready", ar_ready, 1);
      @(posedge clk); #1;
      ar_valid = 0;
      @(negedge clk);
      chk(a_valid && a_opcode == 3'd4, "R4 Get opcode", a_opcode, 3'd4);
      chk(a_address == addr && a_source == id, "R4 read fields", a_address, addr);
      chk(a_size == size, "R11 read size unchanged", a_size, size);
      drain_a("R5 read clears");
   endtask

   task automatic t_hold();
      @(negedge clk);
      ar_valid = 1; ar_addr = 32'hDEAD_0000; ar_id = 6'd9; ar_size = 3'd3;
      @(posedge clk); #1;
      ar_valid = 0;
      for (int k = 0; k < 2; k++) begin
         @(negedge clk);
         aw_valid = 1; w_valid = 1; ar_valid = 1;
         aw_addr = 32'h1; ar_addr = 32'h2; ar_id = 6'd1;
         #1;
         chk(!aw_ready && !w_ready && !ar_ready, "R5 no accept while pending",
             {aw_ready, w_ready, ar_ready}, 0);
         chk(a_valid && a_address == 32'hDEAD_0000 && a_source == 6'd9 &&
             a_size == 3'd3 && a_opcode == 3'd4, "R5 message held", a_address,
             32'hDEAD_0000);
      end
      aw_valid = 0; w_valid = 0; ar_valid = 0;
      drain_a("R5 clears after hold");
   endtask

   task automatic t_priority();
      @(negedge clk);
      aw_valid = 1; w_valid = 1; aw_addr = 32'h100; aw_id = 6'd3; aw_size = 3'd5;
      w_strb = '1; w_data = 256'h1234;
      ar_valid = 1; ar_addr = 32'h200; ar_id = 6'd4; ar_size = 3'd2;
      #1;
      chk(aw_ready && !ar_ready, "R9 write taken first", {aw_ready, ar_ready}, 2'b10);
      @(posedge clk); #1;
      aw_valid = 0; w_valid = 0;
      @(negedge clk);
      chk(a_opcode == 3'd0 && a_source == 6'd3, "R9 write issued", a_opcode, 0);
      a_ready = 1;
      @(posedge clk); #1;
      a_ready = 0;
      @(negedge clk);
      chk(ar_ready, "R9 read taken after", ar_ready, 1);
      @(posedge clk); #1;
      ar_valid = 0;
      @(negedge clk);
      chk(a_valid && a_opcode == 3'd4 && a_source == 6'd4, "R9 read issued",
          a_opcode, 3'd4);
      drain_a("R9 read clears");
   endtask

   task automatic t_ack(input logic [5:0] src, input logic err);
      @(negedge clk);
      d_valid = 1; d_opcode = 3'd0; d_source = src; d_error = err; b_ready = 0;
      #1;
      chk(b_valid && !r_valid, "R6 write response shown", {b_valid, r_valid}, 2'b10);
      chk(!d_ready, "R8 D held while AXI stalls", d_ready, 0);
      b_ready = 1;
      #1;
      chk(d_ready, "R8 D taken with AXI transfer", d_ready, 1);
      chk(b_id == src, "R6 write response ID", b_id, src);
      chk(b_resp == (err ? 2'b10 : 2'b00), "R6 write response code", b_resp,
          err ? 2'b10 : 2'b00);
      @(posedge clk); #1;
      d_valid = 0; b_ready = 0;
   endtask

   task automatic t_ackdata(input logic [5:0] src, input logic [255:0] data,
                            input logic err);
      @(negedge clk);
      d_valid = 1; d_opcode = 3'd1; d_source = src; d_data = data; d_error = err;
      r_ready = 0; b_ready = 1;
      #1;
      chk(r_valid && !b_valid, "R7 read beat shown", {r_valid, b_valid}, 2'b10);
      chk(!d_ready, "R8 D held while read stalls", d_ready, 0);
      r_ready = 1;
      #1;
      chk(d_ready, "R8 D taken with read transfer", d_ready, 1);
      chk(r_id == src && r_data == data, "R7 read ID and data", r_data, data);
      chk(r_resp == (err ? 2'b10 : 2'b00), "R7 read response code", r_resp,
          err ? 2'b10 : 2'b00);
      @(posedge clk); #1;
      d_valid = 0; r_ready = 0; b_ready = 0;
   endtask

   task automatic t_reset_mid();
      @(negedge clk);
      ar_valid = 1; ar_addr = 32'h77; ar_id = 6'd7;
      @(posedge clk); #1;
      ar_valid = 0;
      @(negedge clk);
      chk(a_valid, "R10 pending before reset", a_valid, 1);
      rst = 1;
      @(posedge clk); #1;
      @(negedge clk);
      chk(!a_valid, "R10 reset clears pending message", a_valid, 0);
      rst = 0;
      @(negedge clk);
      chk(!a_valid, "R10 stays clear after reset", a_valid, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      t_reset_state();
      @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R2: full 32-byte write, window is the whole word
      t_write(32'h0000_1000, 6'd63, 3'd5, {8{32'hA5A5_0F0F}}, 32'hFFFF_FFFF, 3'd0,
              "R2 full 32-byte write");
      // R2: 4-byte write at lane 8, window lanes 8..11
      t_write(32'h1234_5668, 6'd5, 3'd2, 256'hBEEF, 32'h0000_0F00, 3'd0,
              "R2 full 4-byte write at lane 8");
      // R2: 1-byte write at lane 3
      t_write(32'h0000_0003, 6'd0, 3'd0, 256'h55, 32'h0000_0008, 3'd0,
              "R2 full 1-byte write");
      // R3: 4-byte window lanes 4..7, lane 4 missing
      t_write(32'h0000_0004, 6'd12, 3'd2, 256'h99, 32'h0000_00E0, 3'd1,
              "R3 partial 4-byte write");
      // R3: 8-byte window lanes 16..23, strobe on the wrong block
      t_write(32'h0000_0010, 6'd33, 3'd3, 256'h1, 32'h0000_00FF, 3'd1,
              "R3 partial 8-byte write");
      t_half_write();
      t_read(32'hFFFF_FFE0, 6'd42, 3'd5);
      t_read(32'h0000_0001, 6'd1, 3'd0);
      t_hold();
      t_priority();
      t_ack(6'd17, 1'b0);
      t_ack(6'd50, 1'b1);
      t_ackdata(6'd21, {4{64'h0123_4567_89AB_CDEF}}, 1'b0);
      t_ackdata(6'd60, 256'hFEED, 1'b1);
      t_reset_mid();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule